// File: doc/BRIEF.md
# Dual I2C Slave Address Matcher

This block decides whether a received 7-bit I2C slave address belongs to this device. It holds a primary address, an optional secondary address and a wake enable, all loaded together by a single configuration write. Each time the bus front end presents a complete address with a one-cycle valid strobe, the block answers with four results in the next cycle: a coarse hit, a wake request, an ACK decision and an address select that picks the data buffer for the transfer.

Matching runs in two stages. The coarse stage compares the address with the primary under a mask in which every bit where the primary and secondary differ is ignored. That comparison is cheap and can run in an always-on domain, but it admits aliases. With three differing bits it admits eight addresses. A coarse hit raises the wake request when waking is enabled. The fine stage then accepts only the exact primary or the exact secondary, so the aliases that woke the device are still refused on the bus.

Top module: `dual_addr_match`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, res_vld, coarse_hit, wake_req, ack and addr_sel are all 0.
- R2: A strobe on addr_vld gives exactly one cycle with res_vld high, on the clock edge after the strobe. In every other cycle res_vld, coarse_hit, wake_req, ack and addr_sel are 0.
- R3: ack is 1 only when the address equals the primary, or equals the secondary while the secondary is enabled. addr_sel is 0 for a primary match and 1 for a secondary match. The primary wins when both are equal.
- R4: While the secondary is disabled (cfg_sec_en = 0), the mask is all ones. coarse_hit and ack are then both 1 for the primary address only.
- R5: coarse_hit is 1 when (addr XOR primary) AND mask is zero, where mask bit i is 0 exactly when the primary and secondary differ in bit i. For example, primary 0x24 with secondary 0x34 makes coarse hits on 0x24 and 0x34 and no other address.
- R6: With primary 0x24 and secondary 0x30, coarse_hit is 1 for 0x20, 0x24, 0x30 and 0x34. ack is 1 only for 0x24 and 0x30.
- R7: When wake is enabled, wake_req equals coarse_hit, including for aliases that are refused. When wake is disabled, wake_req stays 0.
- R8: The general-call address 0x00 never gives coarse_hit, wake_req or ack, whatever the configuration.
- R9: Configuration and mask change only in the cycle where cfg_we is high. A strobe in that same cycle uses the old settings, and a strobe in any later cycle uses the new ones. cfg_* values presented without cfg_we have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load all configuration fields this cycle |
| cfg_prim | input | 7 | Primary slave address |
| cfg_sec | input | 7 | Secondary slave address |
| cfg_sec_en | input | 1 | Secondary address enabled |
| cfg_wake_en | input | 1 | Allow coarse hits to raise a wake request |
| addr_in | input | 7 | Received address |
| addr_vld | input | 1 | addr_in is complete this cycle |
| res_vld | output | 1 | Results valid this cycle |
| coarse_hit | output | 1 | Masked comparison matched |
| wake_req | output | 1 | Wake request from a coarse hit |
| ack | output | 1 | Exact match, so the address is ACKed |
| addr_sel | output | 1 | 0 primary buffer, 1 secondary buffer |

## Verification
All four results come from one register stage. They are due in the cycle that follows the addr_vld strobe and must be 0 in every other cycle. The driver pushes the expected result into a queue at the falling edge on which it raises the strobe. The monitor samples one nanosecond after each rising edge. When res_vld is high it pops the queue and compares. When res_vld is low it fails any item still waiting and any stray result bit. A configuration write is modelled in the bench in the same cycle as the write, so strobes sent at the write edge and after it are scored against the correct settings.

// File: rtl/amm_pkg.sv
package amm_pkg;
   typedef struct packed {
      logic coarse;
      logic wake;
      logic ack;
      logic sel;
   } amm_result_t;

   localparam amm_result_t AMM_RESULT_IDLE = '{coarse: 1'b0, wake: 1'b0, ack: 1'b0, sel: 1'b0};
endpackage

// File: rtl/amm_cfg.sv
module amm_cfg #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] prim_in,
   input  logic [ADDR_W-1:0] sec_in,
   input  logic              sec_en_in,
   input  logic              wake_en_in,
   output logic [ADDR_W-1:0] prim,
   output logic [ADDR_W-1:0] sec,
   output logic              sec_en,
   output logic              wake_en,
   output logic [ADDR_W-1:0] mask
);
   logic [ADDR_W-1:0] mask_next;

   // mask bit is significant when the two addresses agree, or when only one address is active
   for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_mask_bit
      assign mask_next[gi] = ~sec_en_in | ~(prim_in[gi] ^ sec_in[gi]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prim    <= '0;
         sec     <= '0;
         sec_en  <= 1'b0;
         wake_en <= 1'b0;
         mask    <= '1;
      end else if (we) begin
         prim    <= prim_in;
         sec     <= sec_in;
         sec_en  <= sec_en_in;
         wake_en <= wake_en_in;
         mask    <= mask_next;
      end
   end

   // R4: single-address mode keeps every bit significant
   a_r4_mask_full: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_en |-> (&mask));
   // R9: nothing moves without a write
   a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(mask) && $stable(prim) && $stable(sec)));
endmodule

// File: rtl/amm_coarse.sv
module amm_coarse #(
   parameter int ADDR_W = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] prim,
   input  logic [ADDR_W-1:0] mask,
   output logic              hit
);
   logic [ADDR_W-1:0] bit_miss;

   for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_cmp
      assign bit_miss[gi] = (addr[gi] ^ prim[gi]) & mask[gi];
   end

   // general call (all zeros) is never claimed
   assign hit = (|addr) & ~(|bit_miss);
endmodule

// File: rtl/amm_fine.sv
module amm_fine #(
   parameter int ADDR_W = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] prim,
   input  logic [ADDR_W-1:0] sec,
   input  logic              sec_en,
   output logic              ack,
   output logic              sel
);
   localparam int N_SLOT = 2;
   logic [ADDR_W-1:0] slot_addr [N_SLOT];
   logic [N_SLOT-1:0] slot_en;
   logic [N_SLOT-1:0] slot_eq;

   assign slot_addr[0] = prim;
   assign slot_addr[1] = sec;
   assign slot_en      = {sec_en, 1'b1};

   for (genvar gs = 0; gs < N_SLOT; gs++) begin : g_slot
      assign slot_eq[gs] = slot_en[gs] & (addr == slot_addr[gs]) & (|addr);
   end

   assign ack = |slot_eq;
   // primary has priority when both slots hold the same address
   assign sel = ~slot_eq[0] & slot_eq[1];
endmodule

// File: rtl/dual_addr_match.sv
module dual_addr_match #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_prim,
   input  logic [ADDR_W-1:0] cfg_sec,
   input  logic              cfg_sec_en,
   input  logic              cfg_wake_en,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              addr_vld,
   output logic              res_vld,
   output logic              coarse_hit,
   output logic              wake_req,
   output logic              ack,
   output logic              addr_sel
);
   import amm_pkg::*;

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_width
      $error("dual_addr_match: ADDR_W must be in 2..10");
   end

   logic [ADDR_W-1:0] prim_q, sec_q, mask_q;
   logic              sec_en_q, wake_en_q;
   logic              hit_c, ack_c, sel_c;
   amm_result_t       res_d, res_q;
   logic              vld_q;

   amm_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we),
      .prim_in(cfg_prim), .sec_in(cfg_sec),
      .sec_en_in(cfg_sec_en), .wake_en_in(cfg_wake_en),
      .prim(prim_q), .sec(sec_q), .sec_en(sec_en_q),
      .wake_en(wake_en_q), .mask(mask_q)
   );

   amm_coarse #(.ADDR_W(ADDR_W)) u_coarse (
      .addr(addr_in), .prim(prim_q), .mask(mask_q), .hit(hit_c)
   );

   amm_fine #(.ADDR_W(ADDR_W)) u_fine (
      .addr(addr_in), .prim(prim_q), .sec(sec_q), .sec_en(sec_en_q),
      .ack(ack_c), .sel(sel_c)
   );

   always_comb begin
      res_d        = AMM_RESULT_IDLE;
      if (addr_vld) begin
         res_d.coarse = hit_c;
         res_d.wake   = hit_c & wake_en_q;
         res_d.ack    = ack_c;
         res_d.sel    = sel_c;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= AMM_RESULT_IDLE;
         vld_q <= 1'b0;
      end else begin
         res_q <= res_d;
         vld_q <= addr_vld;
      end
   end

   assign res_vld    = vld_q;
   assign coarse_hit = res_q.coarse;
   assign wake_req   = res_q.wake;
   assign ack        = res_q.ack;
   assign addr_sel   = res_q.sel;

   // R2: result exactly one cycle after the strobe, silent otherwise
   a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld |=> res_vld);
   a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> !(coarse_hit || wake_req || ack || addr_sel));
   // R6: exact stage only narrows the coarse stage
   a_r6_fine_in_coarse: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> coarse_hit);
   // R3: secondary select implies ACK
   a_r3_sel_acked: assert property (@(posedge clk) disable iff (!rst_n)
      addr_sel |-> ack);
   // R7: wake only on coarse hit
   a_r7_wake_coarse: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> coarse_hit);
   // R8: general call is never claimed
   a_r8_gen_call: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && addr_in == '0) |=> !(coarse_hit || ack));
endmodule

// File: tb/dual_addr_match_tb.sv
module dual_addr_match_tb;
   localparam int AW = 7;

   typedef struct {
      logic [AW-1:0] addr;
      logic          coarse;
      logic          wake;
      logic          ack;
      logic          sel;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_prim = '0, cfg_sec = '0;
   logic          cfg_sec_en = 1'b0, cfg_wake_en = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          addr_vld = 1'b0;
   logic          res_vld, coarse_hit, wake_req, ack, addr_sel;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   exp_t q[$];

   logic [AW-1:0] m_prim = '0, m_sec = '0;
   logic          m_sen = 1'b0, m_wen = 1'b0;

   always #4 clk = ~clk;

   dual_addr_match #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prim(cfg_prim),
      .cfg_sec(cfg_sec), .cfg_sec_en(cfg_sec_en), .cfg_wake_en(cfg_wake_en),
      .addr_in(addr_in), .addr_vld(addr_vld), .res_vld(res_vld),
      .coarse_hit(coarse_hit), .wake_req(wake_req), .ack(ack), .addr_sel(addr_sel)
   );

   function automatic exp_t model(input logic [AW-1:0] a);
      exp_t e;
      logic [AW-1:0] msk;
      msk      = m_sen ? ~(m_prim ^ m_sec) : '1;
      e.addr   = a;
      e.coarse = (a != 0) && (((a ^ m_prim) & msk) == 0);
      e.wake   = e.coarse && m_wen;
      e.ack    = (a != 0) && ((a == m_prim) || (m_sen && a == m_sec));
      e.sel    = e.ack && (a != m_prim);
      return e;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [AW-1:0] p, input logic [AW-1:0] s,
                            input logic se, input logic we_n);
      @(negedge clk);
      cfg_we = 1'b1; cfg_prim = p; cfg_sec = s; cfg_sec_en = se; cfg_wake_en = we_n;
      @(negedge clk);
      cfg_we = 1'b0;
      m_prim = p; m_sec = s; m_sen = se; m_wen = we_n;
   endtask

   task automatic send(input logic [AW-1:0] a);
      @(negedge clk);
      addr_in = a; addr_vld = 1'b1;
      q.push_back(model(a));
      @(negedge clk);
      addr_vld = 1'b0;
   endtask

   // monitor: sample 1 ns after each rising edge
   always begin
      @(posedge clk);
      #1;
      if (rst_n) begin
         if (res_vld) begin
            if (q.size() == 0) begin
               check("R2", "unexpected res_vld", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check("R5", $sformatf("coarse_hit addr=%0h", e.addr), int'(coarse_hit), int'(e.coarse));
               check("R7", $sformatf("wake_req addr=%0h", e.addr), int'(wake_req), int'(e.wake));
               check("R3", $sformatf("ack addr=%0h", e.addr), int'(ack), int'(e.ack));
               check("R3", $sformatf("addr_sel addr=%0h", e.addr), int'(addr_sel), int'(e.sel));
            end
         end else begin
            if (q.size() != 0) begin
               check("R2", "missing res_vld", 0, 1);
               void'(q.pop_front());
            end
            if (coarse_hit || wake_req || ack || addr_sel)
               check("R2", "result bits outside res_vld",
                     int'({coarse_hit, wake_req, ack, addr_sel}), 0);
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check("R1", "outputs in reset",
            int'({res_vld, coarse_hit, wake_req, ack, addr_sel}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "outputs after reset",
            int'({res_vld, coarse_hit, wake_req, ack, addr_sel}), 0);

      // R5: one differing bit -> two coarse matches
      write_cfg(7'h24, 7'h34, 1'b1, 1'b1);
      for (int a = 0; a < 128; a++) send(AW'(a));

      // R6, R7: two differing bits -> four coarse matches, aliases NACKed, wake on aliases
      write_cfg(7'h24, 7'h30, 1'b1, 1'b1);
      for (int a = 0; a < 128; a++) send(AW'(a));
      send(7'h20); send(7'h34);

      // R7: wake disabled
      write_cfg(7'h24, 7'h30, 1'b1, 1'b0);
      send(7'h20); send(7'h24); send(7'h30);

      // R4: secondary disabled
      write_cfg(7'h24, 7'h30, 1'b0, 1'b1);
      for (int a = 0; a < 128; a++) send(AW'(a));

      // R8: config whose mask admits 0x00
      write_cfg(7'h01, 7'h00, 1'b1, 1'b1);
      send(7'h00); send(7'h01); send(7'h02);

      // R3: primary equals secondary -> primary priority
      write_cfg(7'h55, 7'h55, 1'b1, 1'b0);
      send(7'h55);

      // R9: inputs without cfg_we are ignored
      write_cfg(7'h12, 7'h13, 1'b1, 1'b1);
      @(negedge clk);
      cfg_prim = 7'h40; cfg_sec = 7'h41; cfg_sec_en = 1'b0; cfg_wake_en = 1'b0;
      send(7'h12); send(7'h13); send(7'h40);

      // R9: strobe in the write cycle uses old settings, next strobe new
      @(negedge clk);
      cfg_we = 1'b1; cfg_prim = 7'h40; cfg_sec = 7'h41; cfg_sec_en = 1'b1; cfg_wake_en = 1'b1;
      addr_in = 7'h12; addr_vld = 1'b1;
      q.push_back(model(7'h12));
      @(negedge clk);
      cfg_we = 1'b0;
      m_prim = 7'h40; m_sec = 7'h41; m_sen = 1'b1; m_wen = 1'b1;
      addr_in = 7'h41;
      q.push_back(model(7'h41));
      @(negedge clk);
      addr_vld = 1'b0;
      send(7'h12);

      repeat (4) @(negedge clk);
      check("R2", "queue drained", q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule